// File: doc/BRIEF.md
# External Interrupt Source Selector

This block gathers the external interruption requests of one processor and chooses which one is taken next. Three kinds of source feed it. The first is a stack of events pushed in by software, each with its own code and two parameters. The second is a time-of-day comparator strobe. The third is a CPU interval-timer strobe. A timer strobe is not serviced when it arrives. It leaves a sticky pending bit behind and raises the summary request line toward the core.

Whenever external interruptions are enabled and the core is not already handling another exception, the block takes one pending source per cycle, in fixed priority. Taking a stacked event pops the most recently pushed entry. Taking a timer produces a fixed interruption code with zero parameters. The choice is presented as a one-cycle take pulse that carries the code and both parameters. The summary request line falls once nothing is left pending.

Top module: `ext_irq_select`

## Requirements
- R1: While reset is asserted and in the first cycle after it, takePulse, irqReq and errFlag are 0.
- R2: A todStrobe or cpuTmrStrobe pulse sets a sticky pending bit, so irqReq is 1 from the next cycle on. If the gate is closed, no take happens, however long the source stays pending.
- R3: A take happens only in a cycle where extEnable was 1 and excBusy was 0 at the previous clock edge. takePulse lasts one cycle per taken source, and one source is taken per cycle.
- R4: When more than one source is pending, stacked events are taken first, then the time-of-day source, then the CPU timer.
- R5: Taking the time-of-day source gives takeCode 16'h1004. Taking the CPU timer gives takeCode 16'h1005. In both cases takeParam and takeParam64 are 0.
- R6: Stacked events leave in last-in, first-out order. Each carries the pushCode, pushParam and pushParam64 that were given with its push.
- R7: Taking a timer source clears its pending bit, unless a new strobe of that timer arrives in the same cycle. Popping the last stacked entry clears the stacked-event pending state.
- R8: irqReq is 1 exactly when at least one source is still pending. It drops in the cycle after the last pending source is taken.
- R9: A push while DEPTH entries are stored is discarded and sets errFlag, which stays set until reset. The stored entries are left unchanged.
- R10: If a push and a stack pop fall in the same cycle, the pop returns the entry that was on top before that cycle, and the pushed entry is kept for a later take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| extEnable | input | 1 | External interruption enable mask bit |
| excBusy | input | 1 | Another exception is being handled |
| todStrobe | input | 1 | Time-of-day comparator event |
| cpuTmrStrobe | input | 1 | CPU interval-timer event |
| pushValid | input | 1 | Push an injected event |
| pushCode | input | 16 | Code of the pushed event |
| pushParam | input | 32 | 32-bit parameter of the pushed event |
| pushParam64 | input | 64 | 64-bit parameter of the pushed event |
| takePulse | output | 1 | One-cycle pulse: a source was taken |
| takeCode | output | 16 | Interruption code of the taken source |
| takeParam | output | 32 | 32-bit parameter of the taken source |
| takeParam64 | output | 64 | 64-bit parameter of the taken source |
| irqReq | output | 1 | Summary interruption request to the core |
| errFlag | output | 1 | Sticky flag: a push hit a full stack |

## Verification
The check that a take was gated assumes that extEnable and excBusy are only sampled at the clock edge. The bench therefore changes them two nanoseconds after a rising edge and holds them for the whole cycle. The rule that timer codes come with zero parameters is checked on every take that shows 16'h1004. It only holds if software never pushes an event with code 16'h1004, so every pushed code in the bench lies in the 16'h2xxx range. All other properties use only the block's own ports and do not depend on what is stored in the stack.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam logic [15:0] TOD_CODE = 16'h1004;
  localparam logic [15:0] CPU_TMR_CODE = 16'h1005;

  typedef struct packed {
    logic [15:0] code;
    logic [31:0] param;
    logic [63:0] param64;
  } xevt_t;

  typedef struct packed {
    logic popEvt;
    logic pushEvt;
    logic takeTod;
    logic takeCpu;
  } xstrobe_t;
endpackage

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     extEnable,
  input  logic     excBusy,
  input  logic     todStrobe,
  input  logic     cpuTmrStrobe,
  input  logic     pushValid,
  input  logic     stackFull,
  input  logic     stackOne,
  output xstrobe_t strobes,
  output logic     irqReq,
  output logic     errFlag
);
  logic extPend, todPend, cpuPend;
  logic gateOpen;

  assign gateOpen = extEnable && !excBusy;

  always_comb begin
    strobes.pushEvt = pushValid && !stackFull;
    strobes.popEvt  = gateOpen && extPend;
    strobes.takeTod = gateOpen && !extPend && todPend;
    strobes.takeCpu = gateOpen && !extPend && !todPend && cpuPend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      extPend <= 1'b0;
      todPend <= 1'b0;
      cpuPend <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      // a new strobe in the same cycle as a take keeps the bit set
      todPend <= todStrobe || (todPend && !strobes.takeTod);
      cpuPend <= cpuTmrStrobe || (cpuPend && !strobes.takeCpu);
      if (strobes.pushEvt) extPend <= 1'b1;
      else if (strobes.popEvt && stackOne) extPend <= 1'b0;
      if (pushValid && stackFull) errFlag <= 1'b1;
    end
  end

  assign irqReq = extPend || todPend || cpuPend;
endmodule

// File: rtl/ext_irq_stack.sv
module ext_irq_stack
  import ext_irq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  xstrobe_t    strobes,
  input  xevt_t       pushEvt,
  output logic        stackFull,
  output logic        stackOne,
  output logic        takePulse,
  output logic [15:0] takeCode,
  output logic [31:0] takeParam,
  output logic [63:0] takeParam64
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW = AW + 1;

  xevt_t       slots [DEPTH];
  logic [PW-1:0] topPtr;   // two's complement, all ones = empty
  logic [AW-1:0] rdIdx, wrIdx;
  xevt_t       topEvt;

  assign rdIdx     = topPtr[AW-1:0];
  assign wrIdx     = strobes.popEvt ? rdIdx : AW'(rdIdx + 1'b1);
  assign topEvt    = slots[rdIdx];
  assign stackFull = (topPtr == PW'(DEPTH - 1));
  assign stackOne  = (topPtr == '0);

  always_ff @(posedge clk) begin
    if (strobes.pushEvt) slots[wrIdx] <= pushEvt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      topPtr      <= '1;
      takePulse   <= 1'b0;
      takeCode    <= '0;
      takeParam   <= '0;
      takeParam64 <= '0;
    end else begin
      case ({strobes.pushEvt, strobes.popEvt})
        2'b10:   topPtr <= topPtr + 1'b1;
        2'b01:   topPtr <= topPtr - 1'b1;
        default: topPtr <= topPtr;
      endcase
      takePulse <= strobes.popEvt || strobes.takeTod || strobes.takeCpu;
      if (strobes.popEvt) begin
        takeCode    <= topEvt.code;
        takeParam   <= topEvt.param;
        takeParam64 <= topEvt.param64;
      end else if (strobes.takeTod || strobes.takeCpu) begin
        takeCode    <= strobes.takeTod ? TOD_CODE : CPU_TMR_CODE;
        takeParam   <= '0;
        takeParam64 <= '0;
      end
    end
  end
endmodule

// File: rtl/ext_irq_select.sv
module ext_irq_select
  import ext_irq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        extEnable,
  input  logic        excBusy,
  input  logic        todStrobe,
  input  logic        cpuTmrStrobe,
  input  logic        pushValid,
  input  logic [15:0] pushCode,
  input  logic [31:0] pushParam,
  input  logic [63:0] pushParam64,
  output logic        takePulse,
  output logic [15:0] takeCode,
  output logic [31:0] takeParam,
  output logic [63:0] takeParam64,
  output logic        irqReq,
  output logic        errFlag
);
  xstrobe_t strobes;
  logic     stackFull, stackOne;
  xevt_t    pushEvt;

  assign pushEvt = '{code: pushCode, param: pushParam, param64: pushParam64};

  ext_irq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .extEnable(extEnable), .excBusy(excBusy),
    .todStrobe(todStrobe), .cpuTmrStrobe(cpuTmrStrobe), .pushValid(pushValid),
    .stackFull(stackFull), .stackOne(stackOne), .strobes(strobes),
    .irqReq(irqReq), .errFlag(errFlag)
  );

  ext_irq_stack #(.DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .pushEvt(pushEvt),
    .stackFull(stackFull), .stackOne(stackOne), .takePulse(takePulse),
    .takeCode(takeCode), .takeParam(takeParam), .takeParam64(takeParam64)
  );
endmodule

// File: rtl/ext_irq_select_chk.sv
module ext_irq_select_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        extEnable,
  input logic        excBusy,
  input logic        todStrobe,
  input logic        takePulse,
  input logic [15:0] takeCode,
  input logic [31:0] takeParam,
  input logic [63:0] takeParam64,
  input logic        irqReq,
  input logic        errFlag
);
  // R3
  take_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    takePulse |-> $past(extEnable && !excBusy));

  // R8
  take_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    takePulse |-> $past(irqReq));

  // R5
  tod_zero_param_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (takePulse && takeCode == 16'h1004) |-> (takeParam == '0 && takeParam64 == '0));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(errFlag) |-> errFlag);

  // R2
  strobe_raises_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(todStrobe) |-> irqReq);
endmodule

bind ext_irq_select ext_irq_select_chk u_chk (
  .clk(clk), .rst_n(rst_n), .extEnable(extEnable), .excBusy(excBusy),
  .todStrobe(todStrobe), .takePulse(takePulse), .takeCode(takeCode),
  .takeParam(takeParam), .takeParam64(takeParam64), .irqReq(irqReq),
  .errFlag(errFlag)
);

// File: tb/ext_irq_select_bench.sv
module ext_irq_select_bench;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic extEnable = 0, excBusy = 0, todStrobe = 0, cpuTmrStrobe = 0, pushValid = 0;
  logic [15:0] pushCode = '0;
  logic [31:0] pushParam = '0;
  logic [63:0] pushParam64 = '0;
  logic takePulse, irqReq, errFlag;
  logic [15:0] takeCode;
  logic [31:0] takeParam;
  logic [63:0] takeParam64;

  ext_irq_select #(.DEPTH(DEPTH)) u_ext_irq_select (.*);

  always #4 clk = ~clk;

  int testsRun = 0, testsFailed = 0;
  string curReq = "R1";
  bit done = 0;

  // behavioural reference model
  logic [111:0] mStack[$];
  bit mTod = 0, mCpu = 0, mTake = 0, mErr = 0;
  logic [15:0] mCode = '0;
  logic [31:0] mP = '0;
  logic [63:0] mP64 = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mStack.delete(); mTod = 0; mCpu = 0; mTake = 0; mErr = 0;
      mCode = '0; mP = '0; mP64 = '0;
    end else begin
      automatic int preSize = mStack.size();
      automatic logic [111:0] e;
      mTake = 0;
      if (extEnable && !excBusy) begin
        if (preSize > 0) begin
          e = mStack.pop_back();
          mTake = 1; {mCode, mP, mP64} = e;
        end else if (mTod) begin
          mTake = 1; mCode = 16'h1004; mP = 0; mP64 = 0; mTod = 0;
        end else if (mCpu) begin
          mTake = 1; mCode = 16'h1005; mP = 0; mP64 = 0; mCpu = 0;
        end
      end
      if (pushValid) begin
        if (preSize == DEPTH) mErr = 1;
        else mStack.push_back({pushCode, pushParam, pushParam64});
      end
      if (todStrobe) mTod = 1;
      if (cpuTmrStrobe) mCpu = 1;
    end
  end

  task automatic check(bit ok, string what, logic [127:0] act, logic [127:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s actual=%0h expected=%0h", curReq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      automatic bit mReq = (mStack.size() > 0) || mTod || mCpu;
      check(takePulse === mTake, "takePulse", 128'(takePulse), 128'(mTake));
      check(irqReq === mReq, "irqReq", 128'(irqReq), 128'(mReq));
      check(errFlag === mErr, "errFlag", 128'(errFlag), 128'(mErr));
      if (mTake) begin
        check(takeCode === mCode, "takeCode", 128'(takeCode), 128'(mCode));
        check(takeParam === mP, "takeParam", 128'(takeParam), 128'(mP));
        check(takeParam64 === mP64, "takeParam64", 128'(takeParam64), 128'(mP64));
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  int evtNo = 0;
  task automatic setPush(bit v);
    pushValid = v;
    if (v) begin
      evtNo++;
      pushCode = 16'h2000 + 16'(evtNo);
      pushParam = 32'hA500_0000 + 32'(evtNo);
      pushParam64 = {32'hC0DE_0000 + 32'(evtNo), 32'(evtNo * 3)};
    end
  endtask

  task automatic finishRun();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    #400000;
    testsRun++; testsFailed++;
    $display("FAIL watchdog expired during %s actual=running expected=finished", curReq);
    finishRun();
  end

  initial begin
    // R1: reset values
    curReq = "R1";
    tick(3);
    rst_n = 1'b1;
    tick(2);

    // R2: timer strobes with gate closed stay pending
    curReq = "R2";
    todStrobe = 1; tick(); todStrobe = 0;
    tick(5);

    // R3: busy blocks takes; then R5 timer codes and R8 request drop
    curReq = "R3";
    extEnable = 1; excBusy = 1; tick(4);
    curReq = "R5";
    excBusy = 0; tick(2);
    cpuTmrStrobe = 1; tick(); cpuTmrStrobe = 0;
    curReq = "R8";
    tick(3);

    // R6: LIFO order with full payload
    curReq = "R6";
    extEnable = 0;
    repeat (4) begin setPush(1); tick(); end
    setPush(0);
    extEnable = 1; tick(6);

    // R4: all sources pending together
    curReq = "R4";
    extEnable = 0;
    todStrobe = 1; cpuTmrStrobe = 1; setPush(1); tick();
    todStrobe = 0; cpuTmrStrobe = 0; setPush(1); tick(); setPush(0);
    extEnable = 1; tick(6);

    // R7: strobe arriving in the cycle its source is taken
    curReq = "R7";
    todStrobe = 1; tick(); todStrobe = 1; tick(); todStrobe = 0; tick(4);

    // R9: overflow of the stack
    curReq = "R9";
    extEnable = 0;
    for (int i = 0; i < DEPTH + 3; i++) begin setPush(1); tick(); end
    setPush(0); tick(2);
    extEnable = 1; tick(DEPTH + 4);

    // R10: push and pop in the same cycles
    curReq = "R10";
    extEnable = 0; setPush(1); tick(); setPush(1); tick();
    extEnable = 1;
    for (int i = 0; i < 6; i++) begin setPush(i % 2 == 0); tick(); end
    setPush(0); tick(10);

    finishRun();
  end
endmodule